// File: doc/BRIEF.md
# Three-Bank Masked Interrupt Controller

This block gathers 72 level-sensitive interrupt sources into one interrupt line for a processor. The sources form three groups: eight basic lines and two peripheral banks (A and B) of 32 lines each. In software numbering the basic lines are 0 to 7, bank A is 8 to 39 and bank B is 40 to 71. Each source has its own enable bit. Software never writes an enable mask directly. A set register turns on the positions written as one, and a matching clear register turns them off.

Status is masked. A source only shows as pending when it is both asserted and enabled. A summary word lets an interrupt handler find most sources in one read. It holds the basic lines, one any-pending flag per bank, and direct copies of eleven frequently used bank lines. Two further words show the full masked status of each bank. Access is through a single-cycle 32-bit register port. Writes are taken on the clock edge and read data is combinational.

Top module: `tri_bank_irq_ctrl`

## Requirements
- R1: After reset every enable bit is zero, all three enable words read zero, every status word reads zero and `irq_o` is low, whatever the source levels.
- R2: A write to a set register (bank A 0x10, bank B 0x14, basic 0x18) turns on each enable bit whose data bit is 1 and leaves all others unchanged. Reading the same offset returns the enable mask. For the basic group only data bits 7:0 are used and read bits 31:8 are zero.
- R3: A write to a clear register (bank A 0x1C, bank B 0x20, basic 0x24) turns off each enable bit whose data bit is 1 and leaves all others unchanged.
- R4: The bank A status word (0x04) and bank B status word (0x08) read as source level AND enable, bit n holding bank source n.
- R5: Summary word (0x00) bits 7:0 read as basic source level AND enable.
- R6: Summary bit 8 is the OR of all bank A status bits, and bit 9 is the OR of all bank B status bits.
- R7: Summary bits 10..14 copy bank A status bits 7, 9, 10, 18, 19 in that order. Bits 15..20 copy bank B status bits 21, 22, 23, 24, 25, 30 in that order. Bits 31:21 read zero.
- R8: `irq_o` is high exactly when at least one enabled source is asserted. It falls when that source deasserts or is disabled.
- R9: The clear registers and the reserved word 0x0C read zero. Writes to 0x00, 0x04, 0x08 and 0x0C change no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_basic_i | input | 8 | Basic source levels |
| src_bank_a_i | input | 32 | Bank A source levels |
| src_bank_b_i | input | 32 | Bank B source levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Byte address, word aligned |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted enable bit shows up at the ports in two places, one cycle after the write that caused it. The enable word reads back the wrong value, and `irq_o` and the status words reflect the wrong mask as soon as the matching source is driven. A routing error in the summary only shows up when the source involved is the only one active. The sweep therefore drives each of the 72 sources alone and compares every status word. Random mixed masks and source levels then expose OR-reduction and ordering faults that a single source would hide.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int BASIC_W  = 8;
  localparam int BANK_W   = 32;
  localparam int N_SHORT_A = 5;
  localparam int N_SHORT_B = 6;
  localparam int FLAG_A_BIT  = BASIC_W;
  localparam int FLAG_B_BIT  = BASIC_W + 1;
  localparam int SHORT_A_LSB = BASIC_W + 2;
  localparam int SHORT_B_LSB = SHORT_A_LSB + N_SHORT_A;
  localparam int SUM_USED    = SHORT_B_LSB + N_SHORT_B;

  // bank bit positions mirrored into the summary word, in summary order
  localparam int SHORT_A_POS [N_SHORT_A] = '{7, 9, 10, 18, 19};
  localparam int SHORT_B_POS [N_SHORT_B] = '{21, 22, 23, 24, 25, 30};

  // word index = byte address >> 2
  typedef enum logic [3:0] {
    W_SUMMARY  = 4'd0,
    W_STAT_A   = 4'd1,
    W_STAT_B   = 4'd2,
    W_RESERVED = 4'd3,
    W_SET_A    = 4'd4,
    W_SET_B    = 4'd5,
    W_SET_BAS  = 4'd6,
    W_CLR_A    = 4'd7,
    W_CLR_B    = 4'd8,
    W_CLR_BAS  = 4'd9
  } reg_word_e;
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (set_i)  en_q <= en_q | mask_i;
    else if (clr_i)  en_q <= en_q & ~mask_i;
  end

  assign en_o   = en_q;
  assign pend_o = src_i & en_q;

  // R2
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> ((en_q & $past(mask_i)) == $past(mask_i)));
  // R3
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((en_q & $past(mask_i)) == '0));
  // R9
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(en_q));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASIC_W-1:0] pend_basic_i,
  input  logic [BANK_W-1:0]  pend_a_i,
  input  logic [BANK_W-1:0]  pend_b_i,
  output logic [DATA_W-1:0]  sum_o
);
  always_comb begin
    sum_o = '0;
    sum_o[BASIC_W-1:0] = pend_basic_i;
    sum_o[FLAG_A_BIT]  = |pend_a_i;
    sum_o[FLAG_B_BIT]  = |pend_b_i;
    for (int i = 0; i < N_SHORT_A; i++) sum_o[SHORT_A_LSB+i] = pend_a_i[SHORT_A_POS[i]];
    for (int i = 0; i < N_SHORT_B; i++) sum_o[SHORT_B_LSB+i] = pend_b_i[SHORT_B_POS[i]];
  end

  // R6, R7: a mirrored bit never shows without its bank flag
  short_a_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sum_o[SHORT_B_LSB-1:SHORT_A_LSB]) |-> sum_o[FLAG_A_BIT]);
  // R6, R7
  short_b_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sum_o[SUM_USED-1:SHORT_B_LSB]) |-> sum_o[FLAG_B_BIT]);
  // R7
  sum_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o[DATA_W-1:SUM_USED] == '0);
endmodule

// File: rtl/tri_bank_irq_ctrl.sv
module tri_bank_irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  src_basic_i,
  input  logic [31:0] src_bank_a_i,
  input  logic [31:0] src_bank_b_i,
  input  logic        reg_we_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  localparam int NGRP = 3;
  localparam int GRP_BAS = 0, GRP_A = 1, GRP_B = 2;

  reg_word_e word;
  assign word = reg_word_e'(reg_addr_i[ADDR_W-1:2]);

  logic [NGRP-1:0] set_s, clr_s;
  assign set_s[GRP_BAS] = reg_we_i && word == W_SET_BAS;
  assign set_s[GRP_A]   = reg_we_i && word == W_SET_A;
  assign set_s[GRP_B]   = reg_we_i && word == W_SET_B;
  assign clr_s[GRP_BAS] = reg_we_i && word == W_CLR_BAS;
  assign clr_s[GRP_A]   = reg_we_i && word == W_CLR_A;
  assign clr_s[GRP_B]   = reg_we_i && word == W_CLR_B;

  logic [BASIC_W-1:0] en_bas, pend_bas;
  logic [BANK_W-1:0]  en_a, pend_a, en_b, pend_b;
  logic [DATA_W-1:0]  sum;

  irq_en_bank #(.W(BASIC_W)) u_bank_bas (
    .clk_i, .rst_ni, .set_i(set_s[GRP_BAS]), .clr_i(clr_s[GRP_BAS]),
    .mask_i(reg_wdata_i[BASIC_W-1:0]), .src_i(src_basic_i),
    .en_o(en_bas), .pend_o(pend_bas));

  irq_en_bank #(.W(BANK_W)) u_bank_a (
    .clk_i, .rst_ni, .set_i(set_s[GRP_A]), .clr_i(clr_s[GRP_A]),
    .mask_i(reg_wdata_i[BANK_W-1:0]), .src_i(src_bank_a_i),
    .en_o(en_a), .pend_o(pend_a));

  irq_en_bank #(.W(BANK_W)) u_bank_b (
    .clk_i, .rst_ni, .set_i(set_s[GRP_B]), .clr_i(clr_s[GRP_B]),
    .mask_i(reg_wdata_i[BANK_W-1:0]), .src_i(src_bank_b_i),
    .en_o(en_b), .pend_o(pend_b));

  irq_summary u_summary (
    .clk_i, .rst_ni, .pend_basic_i(pend_bas), .pend_a_i(pend_a),
    .pend_b_i(pend_b), .sum_o(sum));

  assign irq_o = (|pend_bas) | (|pend_a) | (|pend_b);

  always_comb begin
    reg_rdata_o = '0;
    unique case (word)
      W_SUMMARY: reg_rdata_o = sum;
      W_STAT_A:  reg_rdata_o = pend_a;
      W_STAT_B:  reg_rdata_o = pend_b;
      W_SET_A:   reg_rdata_o = en_a;
      W_SET_B:   reg_rdata_o = en_b;
      W_SET_BAS: reg_rdata_o[BASIC_W-1:0] = en_bas;
      default:   reg_rdata_o = '0;
    endcase
  end

  // R8: the line agrees with the summary's basic bits and bank flags
  irq_vs_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (sum[FLAG_B_BIT:0] != '0));
  // R9
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({set_s, clr_s}) <= 1);
endmodule

// File: tb/tri_bank_irq_ctrl_tb.sv
module tri_bank_irq_ctrl_tb;
  logic        clk_i = 0, rst_ni = 0;
  logic [7:0]  src_basic_i = '0;
  logic [31:0] src_bank_a_i = '0, src_bank_b_i = '0;
  logic        reg_we_i = 0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  logic [7:0]  m_bas;
  logic [31:0] m_a, m_b;
  logic [31:0] lfsr = 32'h1234_5678;

  localparam logic [5:0] A_SUM = 6'h00, A_STA = 6'h04, A_STB = 6'h08, A_RSV = 6'h0C,
    A_SETA = 6'h10, A_SETB = 6'h14, A_SETS = 6'h18,
    A_CLRA = 6'h1C, A_CLRB = 6'h20, A_CLRS = 6'h24;

  tri_bank_irq_ctrl u_dut (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  function automatic logic [31:0] exp_sum(input logic [7:0] b, input logic [31:0] a,
                                          input logic [31:0] c);
    logic [31:0] r = '0;
    r[7:0] = b; r[8] = |a; r[9] = |c;
    r[10] = a[7]; r[11] = a[9]; r[12] = a[10]; r[13] = a[18]; r[14] = a[19];
    r[15] = c[21]; r[16] = c[22]; r[17] = c[23]; r[18] = c[24]; r[19] = c[25]; r[20] = c[30];
    return r;
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] d;
    logic [7:0] pb = src_basic_i & m_bas;
    logic [31:0] pa = src_bank_a_i & m_a, pc = src_bank_b_i & m_b;
    rd(A_SUM, d);  chk({tag, " R5 R6 R7 summary"}, d, exp_sum(pb, pa, pc));
    rd(A_STA, d);  chk({tag, " R4 status A"}, d, pa);
    rd(A_STB, d);  chk({tag, " R4 status B"}, d, pc);
    chk({tag, " R8 irq"}, {31'd0, irq_o}, {31'd0, (|pb) | (|pa) | (|pc)});
  endtask

  task automatic clear_all();
    wr(A_CLRS, '1); wr(A_CLRA, '1); wr(A_CLRB, '1);
    m_bas = '0; m_a = '0; m_b = '0;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    logic [31:0] d;
    m_bas = '0; m_a = '0; m_b = '0;
    src_basic_i = '1; src_bank_a_i = '1; src_bank_b_i = '1;
    #23 rst_ni = 1;
    @(negedge clk_i);
    // R1
    rd(A_SETA, d); chk("R1 enable A", d, 0);
    rd(A_SETB, d); chk("R1 enable B", d, 0);
    rd(A_SETS, d); chk("R1 enable basic", d, 0);
    check_all("R1 reset");

    // R2
    wr(A_SETA, 32'hF0F0_1234); wr(A_SETA, 32'h0000_0001);
    m_a = 32'hF0F0_1235;
    rd(A_SETA, d); chk("R2 set A accumulate", d, m_a);
    wr(A_SETS, 32'hFFFF_FF05); m_bas = 8'h05;
    rd(A_SETS, d); chk("R2 set basic width", d, 32'h05);
    wr(A_SETB, 32'h4000_0000); m_b = 32'h4000_0000;
    rd(A_SETB, d); chk("R2 set B", d, m_b);
    check_all("R2 mixed");

    // R3
    wr(A_CLRA, 32'h0000_0030); m_a &= ~32'h30;
    rd(A_SETA, d); chk("R3 clear A", d, m_a);
    wr(A_CLRS, 32'h0000_0004); m_bas = 8'h01;
    rd(A_SETS, d); chk("R3 clear basic", d, 32'h01);
    wr(A_CLRB, 32'h0000_0000);
    rd(A_SETB, d); chk("R3 clear zero mask", d, m_b);

    // R9
    rd(A_CLRA, d); chk("R9 clear A reads zero", d, 0);
    rd(A_CLRB, d); chk("R9 clear B reads zero", d, 0);
    rd(A_CLRS, d); chk("R9 clear basic reads zero", d, 0);
    rd(A_RSV, d);  chk("R9 reserved reads zero", d, 0);
    wr(A_SUM, '1); wr(A_STA, '1); wr(A_STB, '1); wr(A_RSV, '1);
    rd(A_SETA, d); chk("R9 ignored writes A", d, m_a);
    rd(A_SETB, d); chk("R9 ignored writes B", d, m_b);
    rd(A_SETS, d); chk("R9 ignored writes basic", d, {24'd0, m_bas});

    // single-source sweep over all 72 numbers
    for (int s = 0; s < 72; s++) begin
      clear_all();
      src_basic_i = '0; src_bank_a_i = '0; src_bank_b_i = '0;
      if (s < 8)       src_basic_i[s] = 1;
      else if (s < 40) src_bank_a_i[s-8] = 1;
      else             src_bank_b_i[s-40] = 1;
      check_all("R8 disabled source");
      if (s < 8)       begin wr(A_SETS, 32'd1 << s);      m_bas[s] = 1; end
      else if (s < 40) begin wr(A_SETA, 32'd1 << (s-8));  m_a[s-8] = 1; end
      else             begin wr(A_SETB, 32'd1 << (s-40)); m_b[s-40] = 1; end
      check_all("R4 R7 sweep enabled");
      @(negedge clk_i);
      src_basic_i = '0; src_bank_a_i = '0; src_bank_b_i = '0;
      check_all("R8 sweep deassert");
    end

    // random masks and levels
    clear_all();
    for (int k = 0; k < 60; k++) begin
      lfsr = nxt(lfsr); wr(A_SETA, lfsr); m_a |= lfsr;
      lfsr = nxt(lfsr); wr(A_CLRA, lfsr & 32'h0F0F_0F0F); m_a &= ~(lfsr & 32'h0F0F_0F0F);
      lfsr = nxt(lfsr); wr(A_SETB, lfsr & 32'h4380_0000); m_b |= lfsr & 32'h4380_0000;
      lfsr = nxt(lfsr); wr(A_CLRB, lfsr & 32'h0300_0000); m_b &= ~(lfsr & 32'h0300_0000);
      lfsr = nxt(lfsr); wr(A_SETS, lfsr); m_bas |= lfsr[7:0];
      lfsr = nxt(lfsr); wr(A_CLRS, lfsr & 32'h55); m_bas &= ~(lfsr[7:0] & 8'h55);
      lfsr = nxt(lfsr); src_bank_a_i = lfsr & nxt(lfsr);
      lfsr = nxt(lfsr); src_bank_b_i = lfsr & nxt(lfsr);
      lfsr = nxt(lfsr); src_basic_i  = lfsr[7:0] & lfsr[15:8] & lfsr[23:16];
      check_all("R4 R5 R6 R7 random");
      rd(A_SETA, d); chk("R2 R3 random enable A", d, m_a);
    end

    // R8: disabling the pending source drops irq
    clear_all();
    src_basic_i = '0; src_bank_a_i = '0; src_bank_b_i = 32'h0000_0100;
    wr(A_SETB, 32'h100); m_b = 32'h100;
    chk("R8 irq on", {31'd0, irq_o}, 1);
    wr(A_CLRB, 32'h100); m_b = 0;
    chk("R8 irq off after clear", {31'd0, irq_o}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule